// File: doc/BRIEF.md
# Indirect Table Access Controller

This block gives a host processor access to two tables that live inside the block. The first is a scheme configuration table of 32 entries, with 23 words in each entry. The second is a port partition table of 64 entries, with two words in each entry. The host never addresses a table directly. It fills a shared staging window of 23 words through a simple word-addressed register port. It then writes one action word that names the table, the entry, the direction and, for port entries, which words take part.

The transfer completes a fixed number of cycles after the action word is written. The GO bit reads back as 1 for that whole interval. When GO drops, the error flag in the same word reports whether the access was legal.

In a scheme partition word, software places scheme n at bit (31 − n). The block stores that word as plain data and does not interpret it.

Top module: `indirect_tbl_ctrl`

## Requirements
- R1: After reset the action word at address 63 reads 0, every window word reads 0, and every table word holds 0.
- R2: A host write to address 63 with bit 31 set, made while GO is clear, starts an access. Bit 31 then reads 1 for exactly ACC_CYCLES clock cycles after the write edge and then reads 0.
- R3: A scheme write copies window words 0..22 into the scheme entry given by bits 20:16, except window word 16, the packet counter word. A scheme write has bit 30 = 0 and bits 25:24 = 00.
- R4: A scheme read copies all 23 words of the selected scheme entry into the window. A scheme read has bit 30 = 1 and bits 25:24 = 00.
- R5: A scheme write with bit 15 set also copies window word 16 into the entry's packet counter word.
- R6: A port write targets the port given by bits 7:0 and has bits 25:24 = 01 and bit 30 = 0. With bit 15 set it copies window word 0 into the entry's scheme partition word. With bit 14 set it copies window word 1 into the entry's classification plan word. A word whose select bit is clear is left unchanged.
- R7: A port read has bit 30 = 1. It loads the scheme partition word into window word 0 when bit 15 is set, and the classification plan word into window word 1 when bit 14 is set. All other window words keep their values.
- R8: An access that names table select 10 or 11, or a port number of 64 or more, changes neither the tables nor the window. Bit 29 reads 1 once GO has dropped. A legal access leaves bit 29 at 0.
- R9: A write to address 63 while GO is set is ignored. Bits 30:0 keep the values of the access in progress.
- R10: Window writes made while GO is set are ignored.
- R11: Window word k sits at address k for k = 0..22. Addresses 23..62 read as 0, and writes to them have no effect.
- R12: Bits 30, 28:0 of the action word read back as last written while idle. Bit 29 cannot be written by the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 6 | Host word address |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
The assertions assume the host issues at most one write per cycle and that an action word is judged only against its own fields: the error decode looks at bits 25:24 and at the port or scheme index held from the start of the access. The stimulus respects this. It drives writes on the falling edge and waits for GO to clear before starting a new access, except in the directed cases that deliberately write during GO. Random operations draw indices, select bits and window data from a fixed-seed generator, and a reference model follows every table and window word.

// File: rtl/itac_pkg.sv
package itac_pkg;
  localparam int WORD_W   = 32;
  localparam int N_WIN    = 23;   // scheme entry size; port entries use words 0 and 1
  localparam int CNT_WORD = 16;   // packet counter word
  localparam int ADDR_W   = 6;
  localparam logic [ADDR_W-1:0] ACT_ADDR = 6'h3F;
  localparam int WIN_IW   = $clog2(N_WIN);

  // action word fields
  localparam int B_GO   = 31;
  localparam int B_RD   = 30;
  localparam int B_ERR  = 29;
  localparam int B_TSH  = 25;
  localparam int B_TSL  = 24;
  localparam int B_SIH  = 20;
  localparam int B_SIL  = 16;
  localparam int B_SELA = 15;   // counter update / scheme partition word
  localparam int B_SELB = 14;   // classification plan word
  localparam int PORT_FW = 8;

  typedef enum logic [1:0] {
    TS_SCHEME = 2'b00,
    TS_PORT   = 2'b01
  } tsel_e;

  typedef logic [N_WIN-1:0][WORD_W-1:0] win_t;
endpackage

// File: rtl/itac_act_seq.sv
module itac_act_seq
  import itac_pkg::*;
#(
  parameter int N_SCHEMES  = 32,
  parameter int N_PORTS    = 64,
  parameter int ACC_CYCLES = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         act_we_i,
  input  logic [WORD_W-1:0]            wdata_i,
  output logic [WORD_W-1:0]            act_o,
  output logic                         busy_o,
  output logic                         fire_o,
  output logic                         fire_ok_o,
  output logic                         rd_o,
  output logic [1:0]                   tsel_o,
  output logic [$clog2(N_SCHEMES)-1:0] sch_idx_o,
  output logic [$clog2(N_PORTS)-1:0]   port_idx_o,
  output logic                         sel_a_o,
  output logic                         sel_b_o
);
  localparam int CW = $clog2(ACC_CYCLES);
  localparam int SW = $clog2(N_SCHEMES);
  localparam int PW = $clog2(N_PORTS);
  localparam logic [CW-1:0] CNT_LOAD = CW'(ACC_CYCLES - 1);
  localparam logic [B_SIH-B_SIL:0] SCH_LIM = (B_SIH-B_SIL+1)'(N_SCHEMES - 1);
  localparam logic [PORT_FW-1:0]  PORT_LIM = PORT_FW'(N_PORTS - 1);

  logic          busy_q, err_q, rd_q;
  logic [28:0]   cmd_lo_q;
  logic [CW-1:0] cnt_q;
  logic          bad;

  logic [B_SIH-B_SIL:0] sch_raw;
  logic [PORT_FW-1:0]   port_raw;

  assign sch_raw  = cmd_lo_q[B_SIH:B_SIL];
  assign port_raw = cmd_lo_q[PORT_FW-1:0];
  assign tsel_o   = cmd_lo_q[B_TSH:B_TSL];

  always_comb begin
    unique case (tsel_o)
      TS_SCHEME: bad = (sch_raw > SCH_LIM);
      TS_PORT:   bad = (port_raw > PORT_LIM);
      default:   bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      rd_q     <= 1'b0;
      cmd_lo_q <= '0;
      cnt_q    <= '0;
    end else if (act_we_i && !busy_q) begin
      rd_q     <= wdata_i[B_RD];
      cmd_lo_q <= wdata_i[28:0];
      err_q    <= 1'b0;
      if (wdata_i[B_GO]) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_LOAD;
      end
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        err_q  <= bad;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign act_o      = {busy_q, rd_q, err_q, cmd_lo_q};
  assign busy_o     = busy_q;
  assign fire_o     = busy_q && (cnt_q == '0);
  assign fire_ok_o  = fire_o && !bad;
  assign rd_o       = rd_q;
  assign sch_idx_o  = sch_raw[SW-1:0];
  assign port_idx_o = port_raw[PW-1:0];
  assign sel_a_o    = cmd_lo_q[B_SELA];
  assign sel_b_o    = cmd_lo_q[B_SELB];

  p_go_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (cnt_q != '0) |=> busy_q);
  p_go_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !busy_q);
  p_go_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(act_we_i && wdata_i[B_GO]));
  p_cmd_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(cmd_lo_q) && $stable(rd_q));
endmodule

// File: rtl/itac_scheme_tbl.sv
module itac_scheme_tbl
  import itac_pkg::*;
#(
  parameter int N_SCHEMES = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic                         upd_cnt_i,
  input  logic [$clog2(N_SCHEMES)-1:0] idx_i,
  input  win_t                         win_i,
  output win_t                         ent_o
);
  localparam int SW = $clog2(N_SCHEMES);

  win_t mem_q [N_SCHEMES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_SCHEMES; s++) mem_q[s] <= '0;
    end else if (we_i) begin
      for (int s = 0; s < N_SCHEMES; s++) begin
        if (idx_i == SW'(s)) begin
          for (int w = 0; w < N_WIN; w++) begin
            if (w != CNT_WORD || upd_cnt_i) mem_q[s][w] <= win_i[w];
          end
        end
      end
    end
  end

  assign ent_o = mem_q[idx_i];

  p_cnt_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !upd_cnt_i |=> mem_q[$past(idx_i)][CNT_WORD] == $past(mem_q[idx_i][CNT_WORD]));
  p_cnt_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && upd_cnt_i |=> mem_q[$past(idx_i)][CNT_WORD] == $past(win_i[CNT_WORD]));
endmodule

// File: rtl/itac_port_tbl.sv
module itac_port_tbl
  import itac_pkg::*;
#(
  parameter int N_PORTS = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_sp_i,
  input  logic                       we_cpp_i,
  input  logic [$clog2(N_PORTS)-1:0] idx_i,
  input  logic [WORD_W-1:0]          sp_i,
  input  logic [WORD_W-1:0]          cpp_i,
  output logic [WORD_W-1:0]          sp_o,
  output logic [WORD_W-1:0]          cpp_o
);
  logic [WORD_W-1:0] sp_q  [N_PORTS];
  logic [WORD_W-1:0] cpp_q [N_PORTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < N_PORTS; p++) begin
        sp_q[p]  <= '0;
        cpp_q[p] <= '0;
      end
    end else begin
      if (we_sp_i)  sp_q[idx_i]  <= sp_i;
      if (we_cpp_i) cpp_q[idx_i] <= cpp_i;
    end
  end

  assign sp_o  = sp_q[idx_i];
  assign cpp_o = cpp_q[idx_i];

  p_sp_untouched_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_sp_i |=> sp_q[$past(idx_i)] == $past(sp_q[idx_i]));
  p_cpp_untouched_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_cpp_i |=> cpp_q[$past(idx_i)] == $past(cpp_q[idx_i]));
endmodule

// File: rtl/itac_win_regs.sv
module itac_win_regs
  import itac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  input  logic              busy_i,
  input  logic              ld_all_i,
  input  win_t              all_i,
  input  logic              ld_w0_i,
  input  logic [WORD_W-1:0] w0_i,
  input  logic              ld_w1_i,
  input  logic [WORD_W-1:0] w1_i,
  output win_t              win_o
);
  for (genvar w = 0; w < N_WIN; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              ld_port;
    logic [WORD_W-1:0] port_d;

    if (w == 0) begin : g_sp
      assign ld_port = ld_w0_i;
      assign port_d  = w0_i;
    end else if (w == 1) begin : g_cpp
      assign ld_port = ld_w1_i;
      assign port_d  = w1_i;
    end else begin : g_none
      assign ld_port = 1'b0;
      assign port_d  = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 word_q <= '0;
      else if (ld_all_i)           word_q <= all_i[w];
      else if (ld_port)            word_q <= port_d;
      else if (host_we_i && !busy_i && host_addr_i == ADDR_W'(w))
                                   word_q <= host_wdata_i;
    end

    assign win_o[w] = word_q;
  end

  p_win_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !ld_all_i && !ld_w0_i && !ld_w1_i |=> $stable(win_o));
  p_port_ld_narrow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_w0_i || ld_w1_i) && !ld_all_i |=> win_o[N_WIN-1:2] == $past(win_o[N_WIN-1:2]));
endmodule

// File: rtl/indirect_tbl_ctrl.sv
module indirect_tbl_ctrl
  import itac_pkg::*;
#(
  parameter int N_SCHEMES  = 32,
  parameter int N_PORTS    = 64,
  parameter int ACC_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [5:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  localparam int SW = $clog2(N_SCHEMES);
  localparam int PW = $clog2(N_PORTS);

  logic [WORD_W-1:0] act;
  logic              busy, fire, fire_ok, rd, sel_a, sel_b;
  logic [1:0]        tsel;
  logic [SW-1:0]     sch_idx;
  logic [PW-1:0]     port_idx;
  logic              act_we, is_sch, is_port;
  logic              sch_we, sch_ld, sp_we, cpp_we, ld_w0, ld_w1;
  win_t              win, sch_ent;
  logic [WORD_W-1:0] sp_rd, cpp_rd;

  assign act_we  = wr_en_i && (addr_i == ACT_ADDR);
  assign is_sch  = (tsel == TS_SCHEME);
  assign is_port = (tsel == TS_PORT);
  assign sch_we  = fire_ok && is_sch  && !rd;
  assign sch_ld  = fire_ok && is_sch  &&  rd;
  assign sp_we   = fire_ok && is_port && !rd && sel_a;
  assign cpp_we  = fire_ok && is_port && !rd && sel_b;
  assign ld_w0   = fire_ok && is_port &&  rd && sel_a;
  assign ld_w1   = fire_ok && is_port &&  rd && sel_b;

  itac_act_seq #(
    .N_SCHEMES (N_SCHEMES),
    .N_PORTS   (N_PORTS),
    .ACC_CYCLES(ACC_CYCLES)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_we_i  (act_we),
    .wdata_i   (wdata_i),
    .act_o     (act),
    .busy_o    (busy),
    .fire_o    (fire),
    .fire_ok_o (fire_ok),
    .rd_o      (rd),
    .tsel_o    (tsel),
    .sch_idx_o (sch_idx),
    .port_idx_o(port_idx),
    .sel_a_o   (sel_a),
    .sel_b_o   (sel_b)
  );

  itac_win_regs u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_we_i   (wr_en_i),
    .host_addr_i (addr_i),
    .host_wdata_i(wdata_i),
    .busy_i      (busy),
    .ld_all_i    (sch_ld),
    .all_i       (sch_ent),
    .ld_w0_i     (ld_w0),
    .w0_i        (sp_rd),
    .ld_w1_i     (ld_w1),
    .w1_i        (cpp_rd),
    .win_o       (win)
  );

  itac_scheme_tbl #(.N_SCHEMES(N_SCHEMES)) u_sch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (sch_we),
    .upd_cnt_i(sel_a),
    .idx_i    (sch_idx),
    .win_i    (win),
    .ent_o    (sch_ent)
  );

  itac_port_tbl #(.N_PORTS(N_PORTS)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_sp_i (sp_we),
    .we_cpp_i(cpp_we),
    .idx_i   (port_idx),
    .sp_i    (win[0]),
    .cpp_i   (win[1]),
    .sp_o    (sp_rd),
    .cpp_o   (cpp_rd)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ACT_ADDR)               rdata_o = act;
    else if (addr_i < ADDR_W'(N_WIN))     rdata_o = win[addr_i[WIN_IW-1:0]];
  end

  p_err_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !fire_ok |=> act[B_ERR] && !act[B_GO]);
  p_err_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_ok |=> !act[B_ERR] && !act[B_GO]);
  p_err_no_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !fire_ok |=> $stable(win));
endmodule

// File: tb/tb_indirect_tbl_ctrl.sv
`timescale 1ns/1ps
module tb_indirect_tbl_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ACC = 4;
  localparam int NW  = 23;
  localparam logic [5:0] ACT = 6'h3F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;

  logic [31:0] sch_m [32][NW];
  logic [31:0] sp_m  [64];
  logic [31:0] cpp_m [64];
  logic [31:0] win_m [NW];

  indirect_tbl_ctrl #(.N_SCHEMES(32), .N_PORTS(64), .ACC_CYCLES(ACC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act_v, exp_v);
    end
  endtask

  task automatic hwr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hrd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] mk(input logic rd, input logic [1:0] ts, input int sidx,
                                     input logic a, input logic b, input int port);
    logic [31:0] v;
    v = 32'h8000_0000;
    v[30] = rd;
    v[25:24] = ts;
    v[20:16] = 5'(sidx);
    v[15] = a;
    v[14] = b;
    v[7:0] = 8'(port);
    return v;
  endfunction

  function automatic logic exp_bad(input logic [31:0] w);
    return (w[25:24] > 2'b01) || (w[25:24] == 2'b01 && w[7:0] >= 8'd64);
  endfunction

  task automatic model_apply(input logic [31:0] w);
    int s, p;
    if (exp_bad(w)) return;
    s = int'(w[20:16]);
    p = int'(w[7:0]);
    if (w[25:24] == 2'b00) begin
      for (int k = 0; k < NW; k++) begin
        if (w[30]) win_m[k] = sch_m[s][k];
        else if (k != 16 || w[15]) sch_m[s][k] = win_m[k];
      end
    end else begin
      if (w[30]) begin
        if (w[15]) win_m[0] = sp_m[p];
        if (w[14]) win_m[1] = cpp_m[p];
      end else begin
        if (w[15]) sp_m[p] = win_m[0];
        if (w[14]) cpp_m[p] = win_m[1];
      end
    end
  endtask

  task automatic cmp_win(input string req);
    logic [31:0] d;
    for (int k = 0; k < NW; k++) begin
      hrd(6'(k), d);
      chk(req, $sformatf("window word %0d", k), d, win_m[k]);
    end
  endtask

  // full access with GO-length, error-flag and readback checks
  task automatic run_act(input logic [31:0] w);
    int n;
    logic [31:0] d;
    logic [31:0] e;
    hwr(ACT, w);
    n = 0;
    hrd(ACT, d);
    while (d[31] && n < 1000) begin
      n++;
      @(negedge clk);
      hrd(ACT, d);
    end
    chk("R2", "GO cycles", 32'(n), 32'(ACC));
    e = {1'b0, w[30], exp_bad(w), w[28:0]};
    chk("R8/R12", "action readback", d, e);
    model_apply(w);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, w0, w1;
    void'($urandom(32'd20240611));
    for (int s = 0; s < 32; s++) for (int k = 0; k < NW; k++) sch_m[s][k] = '0;
    for (int p = 0; p < 64; p++) begin sp_m[p] = '0; cpp_m[p] = '0; end
    for (int k = 0; k < NW; k++) win_m[k] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    hrd(ACT, d);
    chk("R1", "action after reset", d, 32'h0);
    cmp_win("R1");
    run_act(mk(1'b1, 2'b01, 0, 1'b1, 1'b1, 63));
    cmp_win("R1 port 63 reset");
    run_act(mk(1'b1, 2'b00, 31, 1'b0, 1'b0, 0));
    cmp_win("R1 scheme 31 reset");

    // R11: unmapped addresses
    hwr(6'd40, 32'hDEAD_BEEF);
    hrd(6'd40, d);
    chk("R11", "unmapped read", d, 32'h0);
    hrd(6'd23, d);
    chk("R11", "addr 23 read", d, 32'h0);
    cmp_win("R11");

    // R3/R5: counter word kept unless bit 15
    for (int k = 0; k < NW; k++) begin
      win_m[k] = 32'h1000_0000 + 32'(k);
      hwr(6'(k), win_m[k]);
    end
    run_act(mk(1'b0, 2'b00, 3, 1'b0, 1'b0, 0));
    for (int k = 0; k < NW; k++) begin win_m[k] = 32'h5555_0000 + 32'(k); hwr(6'(k), win_m[k]); end
    run_act(mk(1'b1, 2'b00, 3, 1'b0, 1'b0, 0));
    cmp_win("R3/R4");
    hrd(6'd16, d);
    chk("R5", "counter word kept", d, 32'h0);
    hwr(6'd16, 32'hCAFE_0016); win_m[16] = 32'hCAFE_0016;
    run_act(mk(1'b0, 2'b00, 3, 1'b1, 1'b0, 0));
    hwr(6'd16, 32'h0); win_m[16] = 32'h0;
    run_act(mk(1'b1, 2'b00, 3, 1'b0, 1'b0, 0));
    hrd(6'd16, d);
    chk("R5", "counter word written", d, 32'hCAFE_0016);

    // R6/R7: port word selection
    hwr(6'd0, 32'hAAAA_0001); win_m[0] = 32'hAAAA_0001;
    hwr(6'd1, 32'hBBBB_0002); win_m[1] = 32'hBBBB_0002;
    run_act(mk(1'b0, 2'b01, 0, 1'b1, 1'b0, 10));
    hwr(6'd0, 32'h0); win_m[0] = 0;
    hwr(6'd1, 32'h7); win_m[1] = 32'h7;
    run_act(mk(1'b1, 2'b01, 0, 1'b1, 1'b1, 10));
    cmp_win("R6/R7");
    hrd(6'd0, d);
    chk("R6", "scheme partition word", d, 32'hAAAA_0001);
    hrd(6'd1, d);
    chk("R6", "plan word untouched", d, 32'h0);

    // R8: illegal accesses
    hwr(6'd0, 32'h1234_5678); win_m[0] = 32'h1234_5678;
    run_act(mk(1'b0, 2'b01, 0, 1'b1, 1'b1, 64));
    run_act(mk(1'b1, 2'b10, 3, 1'b1, 1'b1, 0));
    run_act(mk(1'b1, 2'b11, 0, 1'b1, 1'b1, 10));
    cmp_win("R8");
    run_act(mk(1'b1, 2'b01, 0, 1'b1, 1'b1, 0));
    cmp_win("R8 port 0 unchanged");

    // R9: action write during GO ignored
    w0 = mk(1'b1, 2'b00, 3, 1'b0, 1'b0, 0);
    hwr(ACT, w0);
    hwr(ACT, mk(1'b0, 2'b00, 9, 1'b1, 1'b0, 0));
    repeat (ACC + 2) @(negedge clk);
    hrd(ACT, d);
    chk("R9", "action kept", d, {1'b0, w0[30:0]});
    model_apply(w0);
    cmp_win("R9");
    run_act(mk(1'b1, 2'b00, 9, 1'b0, 1'b0, 0));
    cmp_win("R9 scheme 9 untouched");

    // R10: window write during GO ignored
    w1 = mk(1'b0, 2'b00, 2, 1'b0, 1'b0, 0);
    hwr(ACT, w1);
    hwr(6'd0, 32'hDEAD_0000);
    repeat (ACC + 2) @(negedge clk);
    model_apply(w1);
    cmp_win("R10");
    run_act(mk(1'b1, 2'b00, 2, 1'b0, 1'b0, 0));
    cmp_win("R10 scheme 2 content");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: for (int j = 0; j < 5; j++) begin
             int a;
             a = int'($urandom % NW);
             win_m[a] = $urandom;
             hwr(6'(a), win_m[a]);
           end
        1: run_act(mk(1'b0, 2'b00, int'($urandom % 32), 1'($urandom), 1'($urandom), 0));
        2: run_act(mk(1'b1, 2'b00, int'($urandom % 32), 1'($urandom), 1'($urandom), 0));
        3: run_act(mk(1'b0, 2'b01, 0, 1'($urandom), 1'($urandom), int'($urandom % 64)));
        4: run_act(mk(1'b1, 2'b01, 0, 1'($urandom), 1'($urandom), int'($urandom % 64)));
        default:
          if ($urandom % 2 == 0)
            run_act(mk(1'($urandom), 2'b01, 0, 1'b1, 1'b1, 64 + int'($urandom % 192)));
          else
            run_act(mk(1'($urandom), 2'(2 + ($urandom % 2)), int'($urandom % 32), 1'b1, 1'b1, 0));
      endcase
      cmp_win("R3/R4/R6/R7/R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule